// File: doc/BRIEF.md
# Low-Power Mode Wake Controller

This block holds the power mode of a processor core (run, wait, doze or stop) and decides when a pending interrupt request ends a low-power mode. Fast and normal interrupt request vectors come in together with three processor status bits: a fast-enable bit and the interrupt-enable and exception-enable pair. A fast request may wake the core only when fast-enable is set. A normal request may wake the core only when interrupt-enable and exception-enable are both set. The same rule applies in every low-power mode.

The path from the request inputs and status bits to the wake output has no flip-flop on it. A wake can therefore be raised in stop mode, where the clock this block sits on is gated off. The wake also turns the system clock enable back on at once, so the mode register sees a clock edge and returns to run. The block also drives clock enables for the core, the system and the peripherals, and a RAM enable, each decoded from the mode. An input that carries activity from the test-access clock domain is accepted and deliberately ignored.

Top module: `lpwr_wake_ctl`

## Requirements
- R1: A fast request (any bit of `fast_req`) raises `wake` in a low-power mode only while `fast_en` is 1; with `fast_en` at 0, fast requests alone never raise `wake`.
- R2: A normal request (any bit of `norm_req`) raises `wake` in a low-power mode only while both `int_en` and `exc_en` are 1; if either is 0, normal requests alone never raise `wake`.
- R3: `wake` follows the request and status inputs combinationally, with no clock edge between them. This holds in stop mode as well.
- R4: The wake rule of R1 and R2 is the same in wait, doze and stop, and `wake` is 0 whenever the mode is run.
- R5: `pm_mode` reports 00 run, 01 wait, 10 doze, 11 stop, and is run after reset. In run, a cycle with `lp_enter` at 1 moves the mode on the next edge according to `lp_sel`: 00 to wait, 01 to doze, 10 to stop. The value 11 leaves the mode in run.
- R6: In a low-power mode without `wake`, `lp_enter` and `lp_sel` have no effect, and the mode holds.
- R7: With `wake` at 1 in a low-power mode, `pm_mode` is run after the next clock edge.
- R8: `ram_en` is 0 in every low-power mode. It is 1 in the same cycle that `pm_mode` shows run, with no recovery delay.
- R9: `core_clk_en` is 1 only in run. `periph_clk_en` is 0 only in stop. `sys_clk_en` is 0 only in stop while `wake` is 0.
- R10: `tap_evt`, which carries activity from the test-access clock domain, never changes `wake`, the mode or any enable output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock for the mode register |
| rst_n | input | 1 | Active-low asynchronous reset |
| lp_enter | input | 1 | Strobe requesting entry into a low-power mode |
| lp_sel | input | 2 | Requested mode: 00 wait, 01 doze, 10 stop |
| fast_req | input | N_FAST | Fast interrupt request lines |
| norm_req | input | N_NORM | Normal interrupt request lines |
| fast_en | input | 1 | Status bit that allows fast requests to wake |
| int_en | input | 1 | Interrupt-enable status bit |
| exc_en | input | 1 | Exception-enable status bit |
| tap_evt | input | 1 | Test-access clock domain activity, ignored |
| pm_mode | output | 2 | Current power mode |
| wake | output | 1 | Combinational wake decision |
| core_clk_en | output | 1 | Core clock enable |
| sys_clk_en | output | 1 | System clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| ram_en | output | 1 | RAM enable |

## Verification
A mode register stuck in, or falling into, the wrong state shows at the ports within one clock edge: `pm_mode` takes a value other than the one expected, and the enable outputs follow it in the same cycle. For example, a stuck mode gives a RAM that stays on in a low-power mode, or a system clock that stays off while a wake is pending. A wrong qualification term shows as a wrong `wake` level. It is visible a moment after the inputs change, before any edge. On the following edge it also shows as a mode that leaves, or fails to leave, low power. The bench sweeps every request pattern against every combination of status bits and test activity, in each mode.

// File: rtl/lpwr_pkg.sv
package lpwr_pkg;

   typedef enum logic [1:0] {
      PM_RUN  = 2'b00,
      PM_WAIT = 2'b01,
      PM_DOZE = 2'b10,
      PM_STOP = 2'b11
   } pmode_e;

   localparam int unsigned SEL_W = 2;

   localparam logic [SEL_W-1:0] SEL_WAIT = 2'b00;
   localparam logic [SEL_W-1:0] SEL_DOZE = 2'b01;
   localparam logic [SEL_W-1:0] SEL_STOP = 2'b10;

   function automatic pmode_e sel_to_mode(input logic [SEL_W-1:0] sel);
      pmode_e m;
      case (sel)
         SEL_WAIT: m = PM_WAIT;
         SEL_DOZE: m = PM_DOZE;
         SEL_STOP: m = PM_STOP;
         default:  m = PM_RUN;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/lpwr_req_reduce.sv
module lpwr_req_reduce #(
   parameter int unsigned N_REQ    = 4,
   parameter bit          USE_TREE = 1'b1
) (
   input  logic [N_REQ-1:0] req,
   output logic             any
);

   localparam int unsigned LEVELS = (N_REQ > 1) ? $clog2(N_REQ) : 1;
   localparam int unsigned PAD_N  = 1 << LEVELS;

   if (N_REQ < 1) begin : g_bad_width
      $error("lpwr_req_reduce: N_REQ must be at least 1");
   end

   if (USE_TREE) begin : g_tree
      logic [PAD_N-1:0] lvl [LEVELS+1];
      assign lvl[0] = {{(PAD_N-N_REQ){1'b0}}, req};
      for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
         for (genvar i = 0; i < PAD_N; i++) begin : g_node
            if (i < (PAD_N >> (l + 1))) begin : g_or
               assign lvl[l+1][i] = lvl[l][2*i] | lvl[l][2*i+1];
            end else begin : g_zero
               assign lvl[l+1][i] = 1'b0;
            end
         end
      end
      assign any = lvl[LEVELS][0];
   end else begin : g_chain
      logic [N_REQ:0] acc;
      assign acc[0] = 1'b0;
      for (genvar i = 0; i < N_REQ; i++) begin : g_link
         assign acc[i+1] = acc[i] | req[i];
      end
      assign any = acc[N_REQ];
   end

endmodule

// File: rtl/lpwr_wake_qual.sv
module lpwr_wake_qual #(
   parameter int unsigned N_FAST   = 2,
   parameter int unsigned N_NORM   = 8,
   parameter bit          USE_TREE = 1'b1
) (
   input  logic [N_FAST-1:0] fast_req,
   input  logic [N_NORM-1:0] norm_req,
   input  logic              fast_en,
   input  logic              int_en,
   input  logic              exc_en,
   output logic              fast_any,
   output logic              norm_any,
   output logic              wake_raw
);

   logic fast_ok;
   logic norm_ok;

   lpwr_req_reduce #(.N_REQ(N_FAST), .USE_TREE(USE_TREE)) u_fast_red (
      .req (fast_req),
      .any (fast_any)
   );

   lpwr_req_reduce #(.N_REQ(N_NORM), .USE_TREE(USE_TREE)) u_norm_red (
      .req (norm_req),
      .any (norm_any)
   );

   assign fast_ok  = fast_any & fast_en;
   assign norm_ok  = norm_any & int_en & exc_en;
   assign wake_raw = fast_ok | norm_ok;

   // R1 / R2: without any enabled source the raw decision must stay low
   always_comb begin
      if (!fast_en && !(int_en && exc_en)) begin
         assert_no_enabled_source_R1: assert (!wake_raw);
      end
   end

endmodule

// File: rtl/lpwr_mode_fsm.sv
module lpwr_mode_fsm
   import lpwr_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lp_enter,
   input  logic [SEL_W-1:0] lp_sel,
   input  logic             wake,
   output pmode_e           mode_q
);

   pmode_e mode_d;

   always_comb begin
      mode_d = mode_q;
      if (mode_q == PM_RUN) begin
         if (lp_enter) begin
            mode_d = sel_to_mode(lp_sel);
         end
      end else if (wake) begin
         mode_d = PM_RUN;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= PM_RUN;
      end else begin
         mode_q <= mode_d;
      end
   end

   assert_enter_lp_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == PM_RUN && lp_enter && lp_sel != 2'b11) |=> (mode_q != PM_RUN));

   assert_stay_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == PM_RUN && (!lp_enter || lp_sel == 2'b11)) |=> (mode_q == PM_RUN));

   assert_hold_lp_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != PM_RUN && !wake) |=> $stable(mode_q));

   assert_exit_lp_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != PM_RUN && wake) |=> (mode_q == PM_RUN));

endmodule

// File: rtl/lpwr_gate_dec.sv
module lpwr_gate_dec
   import lpwr_pkg::*;
(
   input  pmode_e mode,
   input  logic   wake,
   output logic   core_clk_en,
   output logic   sys_clk_en,
   output logic   periph_clk_en,
   output logic   ram_en
);

   always_comb begin
      core_clk_en   = 1'b0;
      periph_clk_en = 1'b1;
      ram_en        = 1'b0;
      sys_clk_en    = 1'b1;
      case (mode)
         PM_RUN: begin
            core_clk_en = 1'b1;
            ram_en      = 1'b1;
         end
         PM_WAIT, PM_DOZE: begin
            core_clk_en = 1'b0;
         end
         PM_STOP: begin
            periph_clk_en = 1'b0;
            sys_clk_en    = wake;
         end
         default: begin
            core_clk_en = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/lpwr_wake_ctl.sv
module lpwr_wake_ctl
   import lpwr_pkg::*;
#(
   parameter int unsigned N_FAST   = 2,
   parameter int unsigned N_NORM   = 8,
   parameter bit          USE_TREE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lp_enter,
   input  logic [1:0]        lp_sel,
   input  logic [N_FAST-1:0] fast_req,
   input  logic [N_NORM-1:0] norm_req,
   input  logic              fast_en,
   input  logic              int_en,
   input  logic              exc_en,
   input  logic              tap_evt,
   output logic [1:0]        pm_mode,
   output logic              wake,
   output logic              core_clk_en,
   output logic              sys_clk_en,
   output logic              periph_clk_en,
   output logic              ram_en
);

   if (N_FAST < 1 || N_FAST > 64) begin : g_bad_fast
      $error("lpwr_wake_ctl: N_FAST out of range");
   end
   if (N_NORM < 1 || N_NORM > 64) begin : g_bad_norm
      $error("lpwr_wake_ctl: N_NORM out of range");
   end

   pmode_e mode_q;
   logic   fast_any;
   logic   norm_any;
   logic   wake_raw;
   logic   in_lp;

   // activity from the test-access domain is accepted and never used
   logic   unused_tap;
   assign  unused_tap = tap_evt;

   lpwr_wake_qual #(
      .N_FAST   (N_FAST),
      .N_NORM   (N_NORM),
      .USE_TREE (USE_TREE)
   ) u_qual (
      .fast_req (fast_req),
      .norm_req (norm_req),
      .fast_en  (fast_en),
      .int_en   (int_en),
      .exc_en   (exc_en),
      .fast_any (fast_any),
      .norm_any (norm_any),
      .wake_raw (wake_raw)
   );

   assign in_lp = (mode_q != PM_RUN);
   assign wake  = wake_raw & in_lp;

   lpwr_mode_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .lp_enter (lp_enter),
      .lp_sel   (lp_sel),
      .wake     (wake),
      .mode_q   (mode_q)
   );

   lpwr_gate_dec u_gate (
      .mode          (mode_q),
      .wake          (wake),
      .core_clk_en   (core_clk_en),
      .sys_clk_en    (sys_clk_en),
      .periph_clk_en (periph_clk_en),
      .ram_en        (ram_en)
   );

   assign pm_mode = mode_q;

   assert_fast_wakes_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (pm_mode != 2'b00 && fast_any && fast_en) |-> wake);

   assert_norm_needs_both_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((!fast_any || !fast_en) && (!int_en || !exc_en)) |-> !wake);

   assert_run_no_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pm_mode == 2'b00) |-> !wake);

   assert_ram_back_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pm_mode != 2'b00 && wake) |=> ram_en);

   assert_stop_gates_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pm_mode == 2'b11 && !wake) |-> (!sys_clk_en && !periph_clk_en && !ram_en));

endmodule

// File: tb/lpwr_wake_ctl_tb.sv
module lpwr_wake_ctl_tb_top;

   localparam int CLK_P  = 10;
   localparam int NF     = 2;
   localparam int NN     = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          lp_enter = 1'b0;
   logic [1:0]    lp_sel = 2'b00;
   logic [NF-1:0] fast_req = '0;
   logic [NN-1:0] norm_req = '0;
   logic          fast_en = 1'b0;
   logic          int_en = 1'b0;
   logic          exc_en = 1'b0;
   logic          tap_evt = 1'b0;
   logic [1:0]    pm_mode;
   logic          wake;
   logic          core_clk_en;
   logic          sys_clk_en;
   logic          periph_clk_en;
   logic          ram_en;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   lpwr_wake_ctl #(.N_FAST(NF), .N_NORM(NN), .USE_TREE(1'b1)) dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .lp_enter      (lp_enter),
      .lp_sel        (lp_sel),
      .fast_req      (fast_req),
      .norm_req      (norm_req),
      .fast_en       (fast_en),
      .int_en        (int_en),
      .exc_en        (exc_en),
      .tap_evt       (tap_evt),
      .pm_mode       (pm_mode),
      .wake          (wake),
      .core_clk_en   (core_clk_en),
      .sys_clk_en    (sys_clk_en),
      .periph_clk_en (periph_clk_en),
      .ram_en        (ram_en)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // R8 / R9 enables expected for a given mode and wake level
   task automatic chk_gates(input string tag, input int m, input int w);
      chk({tag, " R8 ram_en"},        ram_en,        (m == 0) ? 1 : 0);
      chk({tag, " R9 core_clk_en"},   core_clk_en,   (m == 0) ? 1 : 0);
      chk({tag, " R9 periph_clk_en"}, periph_clk_en, (m == 3) ? 0 : 1);
      chk({tag, " R9 sys_clk_en"},    sys_clk_en,    (m == 3 && w == 0) ? 0 : 1);
   endtask

   task automatic clear_in();
      fast_req = '0; norm_req = '0;
      fast_en = 1'b0; int_en = 1'b0; exc_en = 1'b0; tap_evt = 1'b0;
      lp_enter = 1'b0;
   endtask

   // force a return to run with an enabled fast request
   task automatic back_to_run();
      if (pm_mode != 2'b00) begin
         fast_req = 1; fast_en = 1'b1;
         @(negedge clk);
         clear_in();
      end
   endtask

   initial begin : watchdog
      #(CLK_P * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      int exp_m;
      int exp_w;
      clear_in();
      #(CLK_P * 2 + 1);
      // R5: reset state
      chk("R5 reset mode", pm_mode, 0);
      chk_gates("reset", 0, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R5: illegal select stays in run
      lp_sel = 2'b11; lp_enter = 1'b1;
      @(negedge clk);
      lp_enter = 1'b0;
      chk("R5 sel 11 ignored", pm_mode, 0);

      for (int s = 0; s < 3; s++) begin
         for (int fr = 0; fr < (1 << NF); fr++) begin
            for (int nr = 0; nr < (1 << NN); nr++) begin
               for (int st = 0; st < 8; st++) begin
                  for (int tp = 0; tp < 2; tp++) begin
                     exp_m = s + 1;
                     exp_w = ((fr != 0) && st[0]) || ((nr != 0) && st[1] && st[2]);

                     // R4: in run the same stimulus must not wake
                     fast_req = fr[NF-1:0]; norm_req = nr[NN-1:0];
                     fast_en = st[0]; int_en = st[1]; exc_en = st[2];
                     tap_evt = tp[0];
                     #1;
                     chk("R4 run no wake", wake, 0);
                     chk_gates("run R10", 0, 0);
                     clear_in();

                     // R5: enter the selected mode
                     lp_sel = s[1:0]; lp_enter = 1'b1;
                     @(negedge clk);
                     lp_enter = 1'b0;
                     chk("R5 enter mode", pm_mode, exp_m);
                     chk_gates("idle lp", exp_m, 0);

                     // R1 R2 R3 R4 R10: combinational decision, no edge yet
                     fast_req = fr[NF-1:0]; norm_req = nr[NN-1:0];
                     fast_en = st[0]; int_en = st[1]; exc_en = st[2];
                     tap_evt = tp[0];
                     #1;
                     if (st[0]) chk("R1 fast wake comb R3", wake, exp_w);
                     else       chk("R2 norm wake comb R3", wake, exp_w);
                     chk_gates("lp R10", exp_m, exp_w);

                     // R6: enter strobe in low power ignored
                     lp_enter = 1'b1; lp_sel = (s == 0) ? 2'b10 : 2'b00;
                     @(negedge clk);
                     lp_enter = 1'b0;
                     // R7 / R8: exit on the next edge with RAM on at once
                     chk("R7 R6 mode after edge", pm_mode, exp_w ? 0 : exp_m);
                     chk("R8 ram same cycle", ram_en, exp_w ? 1 : 0);
                     clear_in();
                     back_to_run();
                     chk("R7 back in run", pm_mode, 0);
                  end
               end
            end
         end
      end

      // R3: wake rises mid-cycle in stop and falls again without an edge
      lp_sel = 2'b10; lp_enter = 1'b1;
      @(negedge clk);
      lp_enter = 1'b0;
      int_en = 1'b1; exc_en = 1'b1;
      #1; norm_req = 1;
      #1; chk("R3 stop wake rises", wake, 1);
      chk("R9 stop sys clk with wake", sys_clk_en, 1);
      norm_req = 0;
      #1; chk("R3 stop wake falls", wake, 0);
      chk("R9 stop sys clk off", sys_clk_en, 0);
      clear_in();
      back_to_run();
      chk("R7 final run", pm_mode, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule